// File: doc/BRIEF.md
# Sequencer for a Successive-Approximation Converter

This block is the digital controller of a 12-bit successive-approximation converter. A host processor sees it as an 8-bit peripheral. The host writes one control byte to pick the input channel, the range and the polarity, the acquisition method and the power behaviour. The block then runs a track phase and a 12-step binary search. It presents the result as a low byte and a high byte on the same 8-bit bus, and it flags completion on an active-low interrupt.

The analog part is outside the block. On each conversion clock the block drives a trial code `sar_trial`. The analog side answers on `cmp_bit` within the same cycle: 1 if the sampled input is at or above the trial level. Each clock cycle of `clk` is one conversion clock. Bus strobes are sampled on `clk`, and their edges are found by comparing each strobe with its value one cycle earlier. There is no data stream with flow control. The result is fetched by bus reads, so all pins are plain control and status signals.

Top module: `adc_seq_core`

## Requirements
- R1: A write is accepted on the clock edge that first sees `wr_n` high after it was low, while `cs_n` is low and `shdn_n` is high. At that edge `din` is latched with this layout: bits 2:0 channel (`mux_sel`), bit 3 bipolar (`bipolar`), bit 4 half range (`range_sel`), bit 5 external acquisition, and bits 7:6 the power code.
- R2: With bit 5 at 0, `track` is high for 6 clocks and conversion then starts by itself. `int_n` falls on the 18th clock edge after the accepting edge.
- R3: With bit 5 at 1, `track` stays high until the next accepted write. If that write has bit 5 at 0, conversion starts and `int_n` falls on the 12th edge after it. If it has bit 5 at 1, the open-ended acquisition starts again.
- R4: Conversion resolves one bit per clock, MSB first. `sar_trial` is the bits decided so far with the bit under test set. The stored result equals the code that the comparator answers describe.
- R5: A read with `hben` low returns result bits 7:0. With `hben` high it returns bits 11:8 in positions 3:0. Positions 7:4 are zero for a unipolar result and copies of bit 11 for a bipolar result. A bipolar result is two's complement, which is the offset-binary search code with its MSB inverted.
- R6: `int_n` is high after reset and falls when a result is stored. It rises again on the edge that sees `rd_n` fall while `cs_n` is low, or on an accepted write.
- R7: An accepted write during conversion aborts it and starts a new acquisition. `int_n` stays high until that new conversion ends.
- R8: `pwr_state` encodes 0 = running, 1 = standby, 2 = full power-down. Power code 10 requests standby and 11 requests full power-down. The request takes effect only on the edge that stores the result. The edge that sees `wr_n` fall while `cs_n` is low and `shdn_n` is high returns the block to 0.
- R9: While `shdn_n` is low, the next edge sets `pwr_state` to 2 and aborts any acquisition or conversion, and writes are ignored. After `shdn_n` rises, the state stays 2 until a write falling edge.
- R10: `clk_internal` is 0 after reset. Power code 00 sets it to 0 and 01 sets it to 1. Codes 10 and 11 leave it unchanged.
- R11: With `cs_n` high, `wr_n` and `rd_n` have no effect and `dout_oe` is 0. Otherwise `dout_oe` is 1 exactly while `rd_n` is low.
- R12: When a write with bit 5 at 0 ends an external acquisition and its channel differs from the one that opened it, `addr_err` goes to 1 and the new channel is used. Any other accepted write clears `addr_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion and sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| hben | input | 1 | High-byte select for reads |
| din | input | 8 | Control byte from the host bus |
| shdn_n | input | 1 | Active-low hardware shutdown |
| cmp_bit | input | 1 | Comparator answer for the current trial |
| dout | output | 8 | Read data byte |
| dout_oe | output | 1 | Read data drive enable (bus released when 0) |
| int_n | output | 1 | Active-low result-ready flag |
| track | output | 1 | Track/hold in tracking phase |
| sar_trial | output | 12 | Trial code for the comparator DAC |
| mux_sel | output | 3 | Selected input channel |
| range_sel | output | 1 | Half-range selection |
| bipolar | output | 1 | Bipolar mode selection |
| clk_internal | output | 1 | Internal conversion clock selected |
| pwr_state | output | 2 | Power state (0 run, 1 standby, 2 full) |
| addr_err | output | 1 | Channel mismatch across an external acquisition |

## Verification
The bench builds the block with its default parameters: a 6-clock internal acquisition and a 12-bit result. This makes the exact latencies checkable: 18 edges from write to interrupt for internal acquisition and 12 for the second write of an external one. Bipolar codes at the MSB boundary (0x800, 0x7FF and zero) exercise the sign inversion and the high-byte sign fill. An abort in mid-conversion, a shutdown during conversion, and deferred standby make every phase transition observable at the ports.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ACQ_INT = 2'd1,
    PH_ACQ_EXT = 2'd2,
    PH_CONV    = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_STBY = 2'd1,
    PWR_FULL = 2'd2
  } pwr_t;

  // Control byte, MSB first; the packing order is the bus layout.
  typedef struct packed {
    logic [1:0] pd;
    logic       acq_ext;
    logic       rng;
    logic       bip;
    logic [2:0] ch;
  } ctrl_t;
endpackage

// File: rtl/adc_strobe_edges.sv
module adc_strobe_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wr_n,
  input  logic rd_n,
  output logic wr_rise,
  output logic wr_fall,
  output logic rd_fall
);
  logic wr_q, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      wr_q <= wr_n;
      rd_q <= rd_n;
    end
  end

  assign wr_rise = !cs_n && !wr_q &&  wr_n;
  assign wr_fall = !cs_n &&  wr_q && !wr_n;
  assign rd_fall = !cs_n &&  rd_q && !rd_n;
endmodule

// File: rtl/adc_phase_fsm.sv
module adc_phase_fsm
  import adc_seq_pkg::*;
#(
  parameter int ACQ_CYCLES = 6,
  parameter int RES_BITS   = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_rise,
  input  logic                        wr_fall,
  input  logic                        rd_fall,
  input  logic                        shdn_n,
  input  ctrl_t                       ctrl_in,
  output phase_t                      phase_q,
  output ctrl_t                       ctrl_q,
  output logic [$clog2(RES_BITS)-1:0] bit_idx,
  output logic                        sar_clear,
  output logic                        sar_step,
  output logic                        conv_last,
  output logic                        track,
  output logic                        int_n,
  output pwr_t                        pwr_q,
  output logic                        clk_int_q,
  output logic                        addr_err
);
  localparam int MAXC  = (ACQ_CYCLES > RES_BITS) ? ACQ_CYCLES : RES_BITS;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam int IDX_W = $clog2(RES_BITS);
  localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_CYCLES - 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(RES_BITS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       ext_ch_q;
  logic [1:0]       pd_pend_q;
  logic             accept, wake;
  logic [CNT_W-1:0] idx_full;

  assign accept    = wr_rise && shdn_n;
  assign wake      = wr_fall && shdn_n;
  assign sar_clear = accept;
  assign sar_step  = (phase_q == PH_CONV) && !accept && shdn_n;
  assign conv_last = sar_step && (cnt_q == CONV_LAST);
  assign idx_full  = CONV_LAST - cnt_q;
  assign bit_idx   = idx_full[IDX_W-1:0];
  assign track     = (phase_q == PH_ACQ_INT) || (phase_q == PH_ACQ_EXT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      ctrl_q    <= '0;
      cnt_q     <= '0;
      ext_ch_q  <= '0;
      pd_pend_q <= 2'b00;
      int_n     <= 1'b1;
      pwr_q     <= PWR_RUN;
      clk_int_q <= 1'b0;
      addr_err  <= 1'b0;
    end else if (!shdn_n) begin
      // hardware shutdown: immediate, aborts any phase
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      pwr_q   <= PWR_FULL;
      if (rd_fall) int_n <= 1'b1;
    end else begin
      if (wake) pwr_q <= PWR_RUN;
      if (rd_fall) int_n <= 1'b1;
      if (accept) begin
        ctrl_q    <= ctrl_in;
        pd_pend_q <= ctrl_in.pd;
        int_n     <= 1'b1;
        cnt_q     <= '0;
        if (!ctrl_in.pd[1]) clk_int_q <= ctrl_in.pd[0];
        if (ctrl_in.acq_ext) begin
          phase_q  <= PH_ACQ_EXT;
          ext_ch_q <= ctrl_in.ch;
          addr_err <= 1'b0;
        end else if (phase_q == PH_ACQ_EXT) begin
          phase_q  <= PH_CONV;
          addr_err <= (ctrl_in.ch != ext_ch_q);
        end else begin
          phase_q  <= PH_ACQ_INT;
          addr_err <= 1'b0;
        end
      end else begin
        unique case (phase_q)
          PH_ACQ_INT: begin
            if (cnt_q == ACQ_LAST) begin
              phase_q <= PH_CONV;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_CONV: begin
            if (cnt_q == CONV_LAST) begin
              phase_q <= PH_IDLE;
              cnt_q   <= '0;
              int_n   <= 1'b0;
              unique case (pd_pend_q)
                2'b10:   pwr_q <= PWR_STBY;
                2'b11:   pwr_q <= PWR_FULL;
                default: pwr_q <= PWR_RUN;
              endcase
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
  parameter int RES_BITS = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        step,
  input  logic                        finish,
  input  logic                        bip,
  input  logic [$clog2(RES_BITS)-1:0] idx,
  input  logic                        cmp_bit,
  output logic [RES_BITS-1:0]         trial,
  output logic [RES_BITS-1:0]         result_q,
  output logic                        result_bip_q
);
  localparam logic [RES_BITS-1:0] ONE     = RES_BITS'(1);
  localparam logic [RES_BITS-1:0] MSB_BIT = ONE << (RES_BITS - 1);

  logic [RES_BITS-1:0] code_q;

  assign trial = code_q | (ONE << idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q       <= '0;
      result_q     <= '0;
      result_bip_q <= 1'b0;
    end else begin
      if (clear)     code_q      <= '0;
      else if (step) code_q[idx] <= cmp_bit;
      if (finish) begin
        // finish only happens with idx == 0: cmp_bit is the LSB
        result_q     <= {code_q[RES_BITS-1:1], cmp_bit} ^ (bip ? MSB_BIT : '0);
        result_bip_q <= bip;
      end
    end
  end
endmodule

// File: rtl/adc_readout.sv
module adc_readout #(
  parameter int RES_BITS = 12
) (
  input  logic                cs_n,
  input  logic                rd_n,
  input  logic                hben,
  input  logic [RES_BITS-1:0] result,
  input  logic                result_bip,
  output logic [7:0]          dout,
  output logic                dout_oe
);
  localparam int HI_W  = RES_BITS - 8;
  localparam int EXT_W = 8 - HI_W;

  logic [7:0] hi_byte;

  assign hi_byte = {{EXT_W{result_bip & result[RES_BITS-1]}}, result[RES_BITS-1:8]};
  assign dout    = hben ? hi_byte : result[7:0];
  assign dout_oe = !cs_n && !rd_n;
endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_seq_pkg::*;
#(
  parameter int ACQ_CYCLES = 6,
  parameter int RES_BITS   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                wr_n,
  input  logic                rd_n,
  input  logic                hben,
  input  logic [7:0]          din,
  input  logic                shdn_n,
  input  logic                cmp_bit,
  output logic [7:0]          dout,
  output logic                dout_oe,
  output logic                int_n,
  output logic                track,
  output logic [RES_BITS-1:0] sar_trial,
  output logic [2:0]          mux_sel,
  output logic                range_sel,
  output logic                bipolar,
  output logic                clk_internal,
  output logic [1:0]          pwr_state,
  output logic                addr_err
);
  localparam int IDX_W = $clog2(RES_BITS);

  logic                wr_rise, wr_fall, rd_fall;
  phase_t              phase_q;
  ctrl_t               ctrl_q;
  pwr_t                pwr_q;
  logic [IDX_W-1:0]    bit_idx;
  logic                sar_clear, sar_step, conv_last;
  logic [RES_BITS-1:0] result_q;
  logic                result_bip_q;

  adc_strobe_edges edges_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .wr_n    (wr_n),
    .rd_n    (rd_n),
    .wr_rise (wr_rise),
    .wr_fall (wr_fall),
    .rd_fall (rd_fall)
  );

  adc_phase_fsm #(
    .ACQ_CYCLES (ACQ_CYCLES),
    .RES_BITS   (RES_BITS)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_rise   (wr_rise),
    .wr_fall   (wr_fall),
    .rd_fall   (rd_fall),
    .shdn_n    (shdn_n),
    .ctrl_in   (ctrl_t'(din)),
    .phase_q   (phase_q),
    .ctrl_q    (ctrl_q),
    .bit_idx   (bit_idx),
    .sar_clear (sar_clear),
    .sar_step  (sar_step),
    .conv_last (conv_last),
    .track     (track),
    .int_n     (int_n),
    .pwr_q     (pwr_q),
    .clk_int_q (clk_internal),
    .addr_err  (addr_err)
  );

  adc_sar_reg #(.RES_BITS(RES_BITS)) sar_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (sar_clear),
    .step         (sar_step),
    .finish       (conv_last),
    .bip          (ctrl_q.bip),
    .idx          (bit_idx),
    .cmp_bit      (cmp_bit),
    .trial        (sar_trial),
    .result_q     (result_q),
    .result_bip_q (result_bip_q)
  );

  adc_readout #(.RES_BITS(RES_BITS)) rdo_i (
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .hben       (hben),
    .result     (result_q),
    .result_bip (result_bip_q),
    .dout       (dout),
    .dout_oe    (dout_oe)
  );

  assign mux_sel   = ctrl_q.ch;
  assign range_sel = ctrl_q.rng;
  assign bipolar   = ctrl_q.bip;
  assign pwr_state = pwr_q;
endmodule

// File: rtl/adc_seq_core_chk.sv
module adc_seq_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       wr_n,
  input logic       shdn_n,
  input logic [7:0] din,
  input logic       int_n,
  input logic       clk_internal,
  input logic [1:0] pwr_state,
  input logic       dout_oe,
  input logic [1:0] phase_q
);
  assert_shdn_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> (pwr_state == 2'd2));

  assert_cs_blocks_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !dout_oe);

  assert_write_clears_int_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wr_n) && !cs_n && shdn_n) |=> int_n);

  assert_int_from_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> ($past(phase_q) == 2'd3));

  assert_clkmode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_internal) |-> ($past(din[7]) == 1'b0));

  assert_pwr_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 2'd3);

  assert_standby_deferred_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr_state) == 2'd0 && pwr_state == 2'd1) |-> ($past(phase_q) == 2'd3));
endmodule

bind adc_seq_core adc_seq_core_chk chk_i (.*);

// File: tb/adc_seq_core_tb_top.sv
`timescale 1ns/1ps
module adc_seq_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, hben = 1'b0, shdn_n = 1'b1;
  logic [7:0]  din = 8'h00;
  logic        cmp_bit;
  logic [7:0]  dout;
  logic        dout_oe, int_n, track, range_sel, bipolar, clk_internal, addr_err;
  logic [11:0] sar_trial;
  logic [2:0]  mux_sel;
  logic [1:0]  pwr_state;
  logic [11:0] tgt = 12'h000;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // behavioural comparator: input at or above trial level
  assign cmp_bit = (sar_trial <= tgt);

  adc_seq_core dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .hben(hben), .din(din), .shdn_n(shdn_n), .cmp_bit(cmp_bit),
    .dout(dout), .dout_oe(dout_oe), .int_n(int_n), .track(track),
    .sar_trial(sar_trial), .mux_sel(mux_sel), .range_sel(range_sel),
    .bipolar(bipolar), .clk_internal(clk_internal), .pwr_state(pwr_state),
    .addr_err(addr_err)
  );

  // {ctrl byte, comparator target, expected low byte, expected high byte}
  localparam logic [35:0] VEC [7] = '{
    36'h00ABCBC0A, 36'h0AABCBC02, 36'h0F12323F9, 36'h15FFFFF0F,
    36'h088000000, 36'h010000000, 36'h0B7FFFFFF
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // returns just after the accepting edge
  task automatic write_byte(input logic [7:0] b);
    @(negedge clk); cs_n = 1'b0; din = b; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(posedge clk); #1; cs_n = 1'b1;
  endtask

  task automatic wait_int(output int n);
    n = 0;
    while (int_n && n < 200) begin
      @(posedge clk); #1; n++;
    end
  endtask

  task automatic read_byte(input logic hb, output logic [7:0] v, output logic oe);
    @(negedge clk); cs_n = 1'b0; hben = hb; rd_n = 1'b0;
    #1; v = dout; oe = dout_oe;
    @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] v;
    logic oe;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset int_n", int_n, 1);
    chk("R8 reset pwr", pwr_state, 0);
    chk("R10 reset clock mode", clk_internal, 0);
    chk("R11 reset oe", dout_oe, 0);
    chk("R2 reset track", track, 0);

    // table walk: internal acquisition conversions
    for (int i = 0; i < 7; i++) begin
      tgt = VEC[i][27:16];
      write_byte(VEC[i][35:28]);
      chk("R2 tracking", track, 1);
      chk("R1 channel", mux_sel, int'(VEC[i][30:28]));
      chk("R1 bipolar", bipolar, int'(VEC[i][31]));
      chk("R1 range", range_sel, int'(VEC[i][32]));
      wait_int(n);
      chk("R2 latency", n, 18);
      read_byte(1'b0, v, oe);
      chk("R11 oe on read", oe, 1);
      chk("R4 low byte", v, int'(VEC[i][15:8]));
      chk("R6 read clears int", int_n, 1);
      read_byte(1'b1, v, oe);
      chk("R5 high byte", v, int'(VEC[i][7:0]));
    end

    // R7 abort by a new write in mid-conversion
    tgt = 12'h456;
    write_byte(8'h00);
    repeat (10) @(posedge clk);
    write_byte(8'h00);
    chk("R7 int high after abort", int_n, 1);
    wait_int(n);
    chk("R7 restart latency", n, 18);
    read_byte(1'b0, v, oe);
    chk("R7 result low", v, 8'h56);

    // R3 external acquisition
    write_byte(8'h23);
    repeat (40) @(posedge clk);
    #1;
    chk("R3 open acquisition track", track, 1);
    chk("R3 no result yet", int_n, 1);
    write_byte(8'h23);
    chk("R3 restart track", track, 1);
    write_byte(8'h03);
    chk("R3 conv started", track, 0);
    wait_int(n);
    chk("R3 latency", n, 12);
    chk("R12 same channel no error", addr_err, 0);
    write_byte(8'h23);
    write_byte(8'h05);
    wait_int(n);
    chk("R12 mismatch flagged", addr_err, 1);
    chk("R12 new channel used", mux_sel, 5);
    write_byte(8'h00);
    chk("R12 cleared", addr_err, 0);
    wait_int(n);

    // R8 deferred standby and wake
    write_byte(8'h80);
    chk("R8 not yet standby", pwr_state, 0);
    wait_int(n);
    chk("R8 standby after conv", pwr_state, 1);
    write_byte(8'h00);
    chk("R8 wake on write", pwr_state, 0);
    wait_int(n);

    // R10 clock mode
    write_byte(8'h40);
    chk("R10 internal clock", clk_internal, 1);
    wait_int(n);
    write_byte(8'hC0);
    chk("R10 kept through pd", clk_internal, 1);
    wait_int(n);
    chk("R8 full pd after conv", pwr_state, 2);
    write_byte(8'h00);
    chk("R10 external again", clk_internal, 0);
    chk("R8 wake from full", pwr_state, 0);
    wait_int(n);

    // R9 hardware shutdown
    write_byte(8'h00);
    repeat (10) @(posedge clk);
    @(negedge clk); shdn_n = 1'b0;
    @(posedge clk); #1;
    chk("R9 full at once", pwr_state, 2);
    chk("R9 aborted", track, 0);
    write_byte(8'h05);
    chk("R9 write ignored", mux_sel, 0);
    repeat (30) @(posedge clk);
    #1;
    chk("R9 no completion", int_n, 1);
    @(negedge clk); shdn_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 stays down", pwr_state, 2);
    write_byte(8'h00);
    chk("R9 wake", pwr_state, 0);
    wait_int(n);
    chk("R9 conv after wake", n, 18);

    // R11 strobes blocked with chip select high
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
    @(posedge clk); #1;
    chk("R11 oe blocked", dout_oe, 0);
    @(negedge clk); wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(posedge clk); #1;
    chk("R11 read ignored", int_n, 0);
    chk("R11 write ignored", track, 0);
    @(negedge clk); rd_n = 1'b1;
    read_byte(1'b0, v, oe);
    chk("R6 cleared by real read", int_n, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule